// File: doc/BRIEF.md
# Video Line Counter and Vertical Blanking Generator

This block sits behind a sync separator and works only on clock-enable strobes that are already clean. It counts line-start strobes between successive vertical sync leading edges and latches the result as a 12-bit lines-per-frame figure. That figure comes out as a low byte and a high nibble, together with a one-cycle freshness pulse and a sticky valid flag. From the running line position and the latched figure it builds a vertical blanking window. The window covers a set number of lines after the vertical sync leading edge and a set number of lines before the next one. The two line counts come either from configuration inputs or from a small built-in table indexed by the measured frame length.

The block also reports field parity. If the vertical sync leading edge arrives after a mid-line strobe, with no line-start strobe in between, the field is even. Otherwise it is odd. Progressive sources have no mid-line serrations, so the flag stays high for them. By default the flag changes on the trailing edge of vertical sync. A mode input moves the change to the leading edge.

Control is a three-state machine. `ST_SEEK` waits for the first leading edge and moves to `ST_MEASURE`; that edge is transition T1. `ST_MEASURE` counts the first complete frame and moves to `ST_TRACK` at the next leading edge, which is transition T2. `ST_TRACK` holds: every leading edge latches a new figure and the state does not leave. All inputs are synchronous to `clk`, and vertical sync is active high.

Top module: `video_line_blanker`

## Requirements
- R1: After reset, `blank_out`=0, `field_odd`=1, `lpf_lo`=0, `lpf_hi`=0, `lpf_valid`=0 and `lpf_fresh`=0. While in `ST_SEEK` (before the first vertical sync leading edge), `blank_out` stays 0 whatever the line strobes do.
- R2: The lines-per-frame figure equals the number of `line_stb` strobes between two consecutive leading edges. It saturates at 4095. A strobe in the same cycle as the edge counts toward the frame that is closing.
- R3: The figure appears as `lpf_lo` = bits 7:0 and `lpf_hi` = bits 11:8. Both update in the cycle after the closing leading edge and hold at every other time.
- R4: `lpf_fresh` is high for exactly the one cycle after each leading edge that closes a counted frame (the second edge and every later one). It is never high after the first edge.
- R5: `lpf_valid` rises in the cycle after the second leading edge (transition T2 into `ST_TRACK`) and then stays high until reset.
- R6: Let k be the number of `line_stb` strobes since the last leading edge. In `ST_MEASURE` and `ST_TRACK`, `blank_out` is 1 whenever k < the after-edge count; an after-edge count of 0 gives no such window.
- R7: In `ST_TRACK`, `blank_out` is also 1 whenever k + before-edge count > the latched figure. A before-edge count of 0 adds nothing within a frame no longer than the previous one.
- R8: With `cfg_auto_blank`=1, the before and after counts come from the latched figure, not from the configuration inputs: below 400 gives 2 and 12; 400 to 799 gives 4 and 16; 800 to 1199 gives 5 and 20; 1200 and above gives 3 and 22. In `ST_MEASURE` the latched figure is 0.
- R9: The parity captured at a leading edge is 0 (even) if a `mid_stb` came after the last `line_stb`, and 1 (odd) otherwise. A source with no mid-line strobes keeps `field_odd` at 1.
- R10: With `cfg_field_on_lead`=0, `field_odd` takes the captured parity in the cycle after the trailing edge of `vsync_in` and holds through the high phase. With `cfg_field_on_lead`=1, it takes the parity in the cycle after the leading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle strobe at each line start |
| mid_stb | input | 1 | One-cycle strobe at each mid-line point |
| vsync_in | input | 1 | Vertical sync, active high, synchronous |
| cfg_auto_blank | input | 1 | 1 selects the table-derived blanking counts |
| cfg_lines_pre | input | 4 | Blanking lines before the sync leading edge |
| cfg_lines_post | input | 7 | Blanking lines after the sync leading edge |
| cfg_field_on_lead | input | 1 | 1 updates the field flag at the sync leading edge |
| blank_out | output | 1 | Vertical blanking window |
| field_odd | output | 1 | Field parity, 1 = odd |
| lpf_lo | output | 8 | Lines-per-frame bits 7:0 |
| lpf_hi | output | 4 | Lines-per-frame bits 11:8 |
| lpf_fresh | output | 1 | One-cycle pulse on a new figure |
| lpf_valid | output | 1 | High once a full frame has been measured |

## Verification
The counter, the freshness pulse, the valid flag and a leading-edge field update are all due one cycle after the edge. The bench reads them at the falling clock edge straight after the rising edge that caught the sync edge. `blank_out` has one more register behind the line counter, so it is due two cycles after a strobe or edge. The bench therefore waits three cycles after each strobe before it compares the window against k, computed from its own strobe tally. Trailing-edge field updates are read two cycles after `vsync_in` falls, and the bench also confirms the old value is still present right after the leading edge.

// File: rtl/vlb_pkg.sv
package vlb_pkg;

    typedef enum logic [1:0] {
        ST_SEEK    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_TRACK   = 2'd2
    } vlb_state_e;

endpackage

// File: rtl/vlb_field.sv
module vlb_field (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_in,
    input  logic line_stb,
    input  logic mid_stb,
    input  logic cfg_field_on_lead,
    output logic vs_lead,
    output logic vs_trail,
    output logic field_odd
);

    logic vsync_q;
    logic mid_seen;
    logic parity_q;

    assign vs_lead  = vsync_in & ~vsync_q;
    assign vs_trail = ~vsync_in & vsync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsync_q   <= 1'b0;
            mid_seen  <= 1'b0;
            parity_q  <= 1'b1;
            field_odd <= 1'b1;
        end else begin
            vsync_q <= vsync_in;
            // position inside the line: cleared at line start, set at mid-line
            if (line_stb)
                mid_seen <= 1'b0;
            else if (mid_stb)
                mid_seen <= 1'b1;
            if (vs_lead)
                parity_q <= ~mid_seen;
            if (vs_lead && cfg_field_on_lead)
                field_odd <= ~mid_seen;
            else if (vs_trail && !cfg_field_on_lead)
                field_odd <= parity_q;
        end
    end

    // R10: the flag only moves at a sync edge
    a_r10_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!vs_lead && !vs_trail) |=> $stable(field_odd));

    // R9: an edge at line start gives an odd field in leading-edge mode
    a_r9_line_start_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_lead && cfg_field_on_lead && !mid_seen) |=> field_odd);

endmodule

// File: rtl/vlb_counter.sv
module vlb_counter
    import vlb_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_stb,
    input  logic             vs_lead,
    output logic [CNT_W-1:0] line_cnt,
    output logic [CNT_W-1:0] lpf,
    output logic             lpf_fresh,
    output logic             meas_active,
    output logic             lpf_valid
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    vlb_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_seen;

    assign cnt_inc  = (line_cnt == CNT_MAX) ? line_cnt : line_cnt + 1'b1;
    assign cnt_seen = line_stb ? cnt_inc : line_cnt;

    // next-state logic: T1 SEEK->MEASURE, T2 MEASURE->TRACK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEEK:    if (vs_lead) state_d = ST_MEASURE;
            ST_MEASURE: if (vs_lead) state_d = ST_TRACK;
            ST_TRACK:   state_d = ST_TRACK;
            default:    state_d = ST_SEEK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_SEEK;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_cnt  <= '0;
            lpf       <= '0;
            lpf_fresh <= 1'b0;
        end else begin
            lpf_fresh <= 1'b0;
            unique case (state_q)
                ST_SEEK: begin
                    line_cnt <= '0;
                end
                ST_MEASURE, ST_TRACK: begin
                    if (vs_lead) begin
                        lpf       <= cnt_seen;
                        lpf_fresh <= 1'b1;
                        line_cnt  <= '0;
                    end else begin
                        line_cnt <= cnt_seen;
                    end
                end
                default: begin
                    line_cnt <= '0;
                end
            endcase
        end
    end

    assign meas_active = (state_q != ST_SEEK);
    assign lpf_valid   = (state_q == ST_TRACK);

    a_r2_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cnt == CNT_MAX && !vs_lead) |=> (line_cnt == CNT_MAX));

    a_r4_fresh_single: assert property (@(posedge clk) disable iff (!rst_n)
        lpf_fresh |=> !lpf_fresh);

    a_r3_figure_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_lead |=> $stable(lpf));

    a_r5_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lpf_valid |=> lpf_valid);

    a_r1_seek_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEEK) |=> (line_cnt == '0));

endmodule

// File: rtl/vlb_window.sv
module vlb_window #(
    parameter int CNT_W  = 12,
    parameter int PRE_W  = 4,
    parameter int POST_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  line_cnt,
    input  logic [CNT_W-1:0]  lpf,
    input  logic              meas_active,
    input  logic              lpf_valid,
    input  logic              cfg_auto_blank,
    input  logic [PRE_W-1:0]  cfg_pre,
    input  logic [POST_W-1:0] cfg_post,
    output logic              blank_out
);

    localparam int SUM_W = CNT_W + 1;

    logic [31:0]       lpf_w;
    logic [PRE_W-1:0]  tab_pre, sel_pre;
    logic [POST_W-1:0] tab_post, sel_post;
    logic              post_hit, pre_hit;

    assign lpf_w = 32'(lpf);

    // default counts chosen by frame length
    always_comb begin
        if (lpf_w < 32'd400) begin
            tab_pre  = PRE_W'(2);
            tab_post = POST_W'(12);
        end else if (lpf_w < 32'd800) begin
            tab_pre  = PRE_W'(4);
            tab_post = POST_W'(16);
        end else if (lpf_w < 32'd1200) begin
            tab_pre  = PRE_W'(5);
            tab_post = POST_W'(20);
        end else begin
            tab_pre  = PRE_W'(3);
            tab_post = POST_W'(22);
        end
    end

    assign sel_pre  = cfg_auto_blank ? tab_pre  : cfg_pre;
    assign sel_post = cfg_auto_blank ? tab_post : cfg_post;

    assign post_hit = SUM_W'(line_cnt) < SUM_W'(sel_post);
    assign pre_hit  = (SUM_W'(line_cnt) + SUM_W'(sel_pre)) > SUM_W'(lpf);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            blank_out <= 1'b0;
        else if (!meas_active)
            blank_out <= 1'b0;
        else
            blank_out <= post_hit | (lpf_valid & pre_hit);
    end

    a_r1_quiet_in_seek: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_active |=> !blank_out);

    a_r6_first_line_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_active && line_cnt == '0 && !cfg_auto_blank && cfg_post != '0) |=> blank_out);

endmodule

// File: rtl/video_line_blanker.sv
module video_line_blanker #(
    parameter int CNT_W  = 12,
    parameter int PRE_W  = 4,
    parameter int POST_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_stb,
    input  logic              mid_stb,
    input  logic              vsync_in,
    input  logic              cfg_auto_blank,
    input  logic [PRE_W-1:0]  cfg_lines_pre,
    input  logic [POST_W-1:0] cfg_lines_post,
    input  logic              cfg_field_on_lead,
    output logic              blank_out,
    output logic              field_odd,
    output logic [7:0]        lpf_lo,
    output logic [CNT_W-9:0]  lpf_hi,
    output logic              lpf_fresh,
    output logic              lpf_valid
);

    logic             vs_lead, vs_trail;
    logic [CNT_W-1:0] line_cnt, lpf;
    logic             meas_active;

    vlb_field u_field (
        .clk               (clk),
        .rst_n             (rst_n),
        .vsync_in          (vsync_in),
        .line_stb          (line_stb),
        .mid_stb           (mid_stb),
        .cfg_field_on_lead (cfg_field_on_lead),
        .vs_lead           (vs_lead),
        .vs_trail          (vs_trail),
        .field_odd         (field_odd)
    );

    vlb_counter #(.CNT_W(CNT_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_stb    (line_stb),
        .vs_lead     (vs_lead),
        .line_cnt    (line_cnt),
        .lpf         (lpf),
        .lpf_fresh   (lpf_fresh),
        .meas_active (meas_active),
        .lpf_valid   (lpf_valid)
    );

    vlb_window #(.CNT_W(CNT_W), .PRE_W(PRE_W), .POST_W(POST_W)) u_window (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_cnt       (line_cnt),
        .lpf            (lpf),
        .meas_active    (meas_active),
        .lpf_valid      (lpf_valid),
        .cfg_auto_blank (cfg_auto_blank),
        .cfg_pre        (cfg_lines_pre),
        .cfg_post       (cfg_lines_post),
        .blank_out      (blank_out)
    );

    assign lpf_lo = lpf[7:0];
    assign lpf_hi = lpf[CNT_W-1:8];

endmodule

// File: tb/video_line_blanker_bench.sv
module video_line_blanker_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0, mid_stb = 1'b0, vsync_in = 1'b0;
    logic       cfg_auto_blank = 1'b0, cfg_field_on_lead = 1'b0;
    logic [3:0] cfg_lines_pre = 4'd3;
    logic [6:0] cfg_lines_post = 7'd5;
    logic       blank_out, field_odd, lpf_fresh, lpf_valid;
    logic [7:0] lpf_lo;
    logic [3:0] lpf_hi;

    always #2 clk = ~clk;

    video_line_blanker u_video_line_blanker (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .mid_stb(mid_stb),
        .vsync_in(vsync_in), .cfg_auto_blank(cfg_auto_blank),
        .cfg_lines_pre(cfg_lines_pre), .cfg_lines_post(cfg_lines_post),
        .cfg_field_on_lead(cfg_field_on_lead), .blank_out(blank_out),
        .field_odd(field_odd), .lpf_lo(lpf_lo), .lpf_hi(lpf_hi),
        .lpf_fresh(lpf_fresh), .lpf_valid(lpf_valid)
    );

    int n_chk = 0, n_fail = 0;
    int st = 0, exp_lpf = 0, exp_field = 1, k = 0;
    bit half_seen = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int tbl_pre(int l);
        if (l < 400) return 2; else if (l < 800) return 4; else if (l < 1200) return 5; else return 3;
    endfunction

    function automatic int tbl_post(int l);
        if (l < 400) return 12; else if (l < 800) return 16; else if (l < 1200) return 20; else return 22;
    endfunction

    task automatic chk_blank();
        int pre, post, e;
        string req;
        pre  = cfg_auto_blank ? tbl_pre(exp_lpf)  : int'(cfg_lines_pre);
        post = cfg_auto_blank ? tbl_post(exp_lpf) : int'(cfg_lines_post);
        e = 0;
        if (st != 0 && (k < post || (st == 2 && k + pre > exp_lpf))) e = 1;
        if (st == 0) req = "R1";
        else if (cfg_auto_blank) req = "R8";
        else if (k < post) req = "R6";
        else req = "R7";
        chk(req, int'(blank_out), e);
    endtask

    task automatic line_step(bit do_chk);
        @(negedge clk) line_stb = 1'b1;
        @(negedge clk) line_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (k < 4095) k++;
        half_seen = 0;
        if (do_chk) chk_blank();
    endtask

    task automatic mid_step();
        @(negedge clk) mid_stb = 1'b1;
        @(negedge clk) mid_stb = 1'b0;
        @(negedge clk);
        half_seen = 1;
    endtask

    task automatic vs_pulse();
        int parity;
        parity = half_seen ? 0 : 1;
        @(negedge clk) vsync_in = 1'b1;
        @(negedge clk);
        if (st >= 1) begin
            chk("R4", int'(lpf_fresh), 1);
            chk("R2", int'({lpf_hi, lpf_lo}), k);
            chk("R3", int'(lpf_lo), k & 255);
            chk("R3", int'(lpf_hi), k >> 8);
            exp_lpf = k;
        end else begin
            chk("R4", int'(lpf_fresh), 0);
        end
        chk("R10", int'(field_odd), cfg_field_on_lead ? parity : exp_field);
        if (st < 2) st++;
        k = 0;
        @(negedge clk);
        chk("R4", int'(lpf_fresh), 0);
        chk("R10", int'(field_odd), cfg_field_on_lead ? parity : exp_field);
        @(negedge clk);
        @(negedge clk) vsync_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        exp_field = parity;
        chk("R9", int'(field_odd), exp_field);
        chk("R5", int'(lpf_valid), (st == 2) ? 1 : 0);
        chk_blank();
    endtask

    task automatic frame(int n, bit even, bit do_chk);
        for (int i = 0; i < n; i++) line_step(do_chk);
        if (even) mid_step();
        vs_pulse();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(blank_out), 0);
        chk("R1", int'(field_odd), 1);
        chk("R1", int'({lpf_hi, lpf_lo}), 0);
        chk("R1", int'(lpf_valid), 0);
        chk("R1", int'(lpf_fresh), 0);
        for (int i = 0; i < 5; i++) line_step(1);
        vs_pulse();                       // T1: no figure yet
        frame(20, 0, 1);                  // T2: first figure
        frame(20, 0, 1);
        for (int p = 0; p < 4; p++) begin
            for (int q = 0; q < 3; q++) begin
                @(negedge clk);
                cfg_lines_pre  = (p == 0) ? 4'd0 : (p == 1) ? 4'd1 : (p == 2) ? 4'd3 : 4'd15;
                cfg_lines_post = (q == 0) ? 7'd0 : (q == 1) ? 7'd2 : 7'd9;
                frame(18, 0, 1);
            end
        end
        cfg_lines_pre = 4'd3; cfg_lines_post = 7'd5;
        frame(12, 0, 1);
        frame(25, 0, 1);                  // longer than previous figure
        frame(10, 1, 1);                  // even field, trailing update
        frame(10, 0, 1);
        cfg_field_on_lead = 1'b1;
        frame(10, 1, 1);                  // even field, leading update
        frame(10, 0, 1);
        cfg_field_on_lead = 1'b0;
        for (int i = 0; i < 3; i++) frame(14, 0, 1);   // progressive: stays odd
        cfg_auto_blank = 1'b1;
        frame(500, 0, 1);
        frame(500, 0, 1);
        frame(300, 0, 1);
        frame(900, 0, 1);
        frame(1300, 0, 1);
        frame(1300, 0, 1);
        cfg_auto_blank = 1'b0;
        frame(4200, 0, 0);                // R2 saturation
        frame(20, 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule